// File: doc/BRIEF.md
# Parallel-Port Block Transfer Engine

This engine moves a block of bytes between a parallel-port-to-IDE bridge and a local byte stream. It uses the three handshake modes that need no hardware port assist. The host loads a mode, a direction and a byte count with a one-cycle start pulse. The engine then plays a fixed setup sequence on the port's data and control lines. It handles each byte in turn and finishes with a short trailer sequence. A one-cycle done pulse marks the end of the transfer.

On a read, a phase bit on the control lines toggles once per byte, and this toggle acknowledges the byte to the bridge. The engine builds each byte in one of three ways. In nibble mode it uses two status samples. In 5/3 mode it combines status with control readback. In byte mode it reads the data lines. Each byte is offered on a valid/ready output stream.

On a write, bytes come from a valid/ready input stream. All modes share one write sequence. The data lines are driven again only when a byte differs from the one already on them, and each byte costs a cycle less when it repeats.

Every step of a sequence is one clock long, and each step writes either the data lines or the control lines.

Top module: `pport_block_xfer`

## Requirements
- R1: After reset, ctl_out is 0x04, bus_dout is 0x00, and busy, done, rd_valid and wr_ready are all low. ctl_out is again 0x04 whenever the engine is idle.
- R2: Nibble read (mode 0, dir 0). The setup writes data 0x81, control 0x01, control 0x03, then data 0xC1. For each byte, control is set to 0x02|ph and status is sampled as A. Control is then set to 0x04|ph and status is sampled as B. The byte is {B[7:4], A[7:4]}. The phase ph starts at 1 and flips after each byte.
- R3: 5/3 read (mode 1, dir 0). The setup writes data 0x91, control 0x01, data 0x10, control 0x03, data 0x51, control 0x05, then data 0xD1. For each byte, control is set to 0x04|ph, and status S and control readback C are sampled in the same cycle. The byte is {C[3:1], S[7:3]}.
- R4: Byte read (mode 2 or 3, dir 0). The setup writes data 0x89, then control 0x01, 0x23 and 0x21. For each byte, control is set to 0x24|ph and the byte is bus_din.
- R5: Read trailers. A nibble or 5/3 read ends with data 0x00 then control 0x04. A byte read ends with control 0x06 then 0x04.
- R6: Write (dir 1, any mode). The setup writes data 0xA1, then control 0x01, 0x03, 0x01 and 0x05, with ph starting at 0. After its data step, each byte sets control to 0x04|ph and ph flips. The transfer ends with control 0x07 then 0x04.
- R7: A written byte is put on bus_dout only when it differs from the previous byte of the same transfer. The first byte is always put on bus_dout. A driven byte costs two cycles and a repeated byte costs one.
- R8: While rd_valid is high and rd_ready is low, rd_data, bus_dout and ctl_out hold their values.
- R9: While wr_ready is high and wr_valid is low, bus_dout and ctl_out hold their values. A byte is taken only on a cycle where wr_valid and wr_ready are both high.
- R10: A count of 0 runs only the setup and trailer sequences and then signals done.
- R11: done is high for exactly one cycle per transfer, and busy is low in the cycle after it. A start pulse while busy is ignored, and mode, dir and count are latched only when a start is accepted.
- R12: Every sequence step takes one cycle. With rd_ready held high, a read byte takes 4 cycles in nibble mode and 3 cycles otherwise. busy is high for setup steps + byte cycles + 2 + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| mode | input | 2 | 0 nibble, 1 5/3, 2 or 3 byte |
| dir | input | 1 | 0 read from bridge, 1 write to bridge |
| count | input | CNT_W | Number of bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| bus_dout | output | 8 | Port data lines driven to the bridge |
| bus_din | input | 8 | Port data lines read back |
| ctl_out | output | 8 | Port control lines |
| ctl_in | input | 8 | Control-line readback |
| stat_in | input | 8 | Port status lines |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer accepts read byte |
| wr_data | input | 8 | Byte to write |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Engine accepts write byte |

## Verification
The assertions allow rd_ready and wr_valid to change in any cycle. They check only that the engine freezes the port lines and the offered byte while a stream stalls, and they assume nothing about the bridge inputs outside the cycles where those inputs are sampled. The bench's bridge model answers only when the control lines carry the exact strobe value that the expected phase calls for, and it returns filler values otherwise, so a wrong phase or a wrong sampling cycle shows up as corrupted bytes. The bench holds wr_data until the byte is accepted, changes the stall patterns from a shift register, and pulses start only while busy when it tests that start is ignored.

// File: rtl/pport_block_xfer.sv
module pport_block_xfer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             dir,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             done,
  output logic [7:0]       bus_dout,
  input  logic [7:0]       bus_din,
  output logic [7:0]       ctl_out,
  input  logic [7:0]       ctl_in,
  input  logic [7:0]       stat_in,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready
);

  localparam logic [1:0] M_NIB = 2'd0;
  localparam logic [1:0] M_53  = 2'd1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_RCTL, S_RA, S_RB, S_ROUT, S_WBYTE, S_WCTL, S_TRAIL, S_FIN
  } state_t;

  state_t           st;
  logic [1:0]       mode_q;
  logic             dir_q;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       idx;
  logic             ph;
  logic [3:0]       nib_a;
  logic             drv_ok;
  logic [9:0]       sstep;
  logic [8:0]       tstep;
  logic [7:0]       ph8;

  wire unused_bits = ^{ctl_in[7:4], ctl_in[0], stat_in[2:0]};

  // {last, is_ctl, value}
  function automatic logic [9:0] setup_step(input logic [1:0] m, input logic wr, input logic [2:0] i);
    logic [9:0] s;
    s = 10'h000;
    if (wr) begin
      case (i)
        3'd0:    s = {2'b00, 8'hA1};
        3'd1:    s = {2'b01, 8'h01};
        3'd2:    s = {2'b01, 8'h03};
        3'd3:    s = {2'b01, 8'h01};
        default: s = {2'b11, 8'h05};
      endcase
    end else if (m == M_NIB) begin
      case (i)
        3'd0:    s = {2'b00, 8'h81};
        3'd1:    s = {2'b01, 8'h01};
        3'd2:    s = {2'b01, 8'h03};
        default: s = {2'b10, 8'hC1};
      endcase
    end else if (m == M_53) begin
      case (i)
        3'd0:    s = {2'b00, 8'h91};
        3'd1:    s = {2'b01, 8'h01};
        3'd2:    s = {2'b00, 8'h10};
        3'd3:    s = {2'b01, 8'h03};
        3'd4:    s = {2'b00, 8'h51};
        3'd5:    s = {2'b01, 8'h05};
        default: s = {2'b10, 8'hD1};
      endcase
    end else begin
      case (i)
        3'd0:    s = {2'b00, 8'h89};
        3'd1:    s = {2'b01, 8'h01};
        3'd2:    s = {2'b01, 8'h23};
        default: s = {2'b11, 8'h21};
      endcase
    end
    return s;
  endfunction

  // {is_ctl, value}
  function automatic logic [8:0] trail_step(input logic [1:0] m, input logic wr, input logic i);
    logic [8:0] s;
    if (i)          s = {1'b1, 8'h04};
    else if (wr)    s = {1'b1, 8'h07};
    else if (m[1])  s = {1'b1, 8'h06};
    else            s = {1'b0, 8'h00};
    return s;
  endfunction

  assign sstep    = setup_step(mode_q, dir_q, idx);
  assign tstep    = trail_step(mode_q, dir_q, idx[0]);
  assign ph8      = {7'd0, ph};
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign rd_valid = (st == S_ROUT);
  assign wr_ready = (st == S_WBYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= 2'd0;
      dir_q    <= 1'b0;
      cnt      <= '0;
      idx      <= 3'd0;
      ph       <= 1'b0;
      nib_a    <= 4'd0;
      drv_ok   <= 1'b0;
      bus_dout <= 8'h00;
      ctl_out  <= 8'h04;
      rd_data  <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode;
          dir_q  <= dir;
          cnt    <= count;
          idx    <= 3'd0;
          ph     <= ~dir;
          drv_ok <= 1'b0;
          st     <= S_SETUP;
        end
        S_SETUP: begin
          if (sstep[8]) ctl_out  <= sstep[7:0];
          else          bus_dout <= sstep[7:0];
          if (sstep[9]) begin
            idx <= 3'd0;
            if (cnt == '0)  st <= S_TRAIL;
            else if (dir_q) st <= S_WBYTE;
            else            st <= S_RCTL;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        S_RCTL: begin
          if (mode_q == M_NIB)     ctl_out <= 8'h02 | ph8;
          else if (mode_q == M_53) ctl_out <= 8'h04 | ph8;
          else                     ctl_out <= 8'h24 | ph8;
          st <= S_RA;
        end
        S_RA: begin
          if (mode_q == M_NIB) begin
            nib_a   <= stat_in[7:4];
            ctl_out <= 8'h04 | ph8;
            st      <= S_RB;
          end else begin
            rd_data <= (mode_q == M_53) ? {ctl_in[3:1], stat_in[7:3]} : bus_din;
            st      <= S_ROUT;
          end
        end
        S_RB: begin
          rd_data <= {stat_in[7:4], nib_a};
          st      <= S_ROUT;
        end
        S_ROUT: if (rd_ready) begin
          ph  <= ~ph;
          cnt <= cnt - ONE;
          st  <= (cnt == ONE) ? S_TRAIL : S_RCTL;
        end
        S_WBYTE: if (wr_valid) begin
          if (!drv_ok || wr_data != bus_dout) begin
            bus_dout <= wr_data;
            drv_ok   <= 1'b1;
            st       <= S_WCTL;
          end else begin
            ctl_out <= 8'h04 | ph8;
            ph      <= ~ph;
            cnt     <= cnt - ONE;
            st      <= (cnt == ONE) ? S_TRAIL : S_WBYTE;
          end
        end
        S_WCTL: begin
          ctl_out <= 8'h04 | ph8;
          ph      <= ~ph;
          cnt     <= cnt - ONE;
          st      <= (cnt == ONE) ? S_TRAIL : S_WBYTE;
        end
        S_TRAIL: begin
          if (tstep[8]) ctl_out  <= tstep[7:0];
          else          bus_dout <= tstep[7:0];
          if (idx[0]) begin
            idx <= 3'd0;
            st  <= S_FIN;
          end else begin
            idx <= 3'd1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pport_block_xfer_chk.sv
module pport_block_xfer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] bus_dout,
  input logic [7:0] ctl_out,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       wr_valid,
  input logic       wr_ready
);

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ctl_out == 8'h04) && !rd_valid && !wr_ready); // R1

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R8

  AST_RD_STALL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> $stable(ctl_out) && $stable(bus_dout)); // R8

  AST_WR_STALL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready && !wr_valid |=> wr_ready && $stable(ctl_out) && $stable(bus_dout)); // R9

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R11

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R11

endmodule

bind pport_block_xfer pport_block_xfer_chk u_chk (.*);

// File: tb/tb_pport_block_xfer.sv
module tb_pport_block_xfer;
  localparam int CW = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0, dir = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [CW-1:0] count = '0;
  logic          busy, done, rd_valid, wr_ready;
  logic [7:0]    bus_dout, ctl_out, rd_data;
  logic [7:0]    bus_din, ctl_in, stat_in;
  logic          rd_ready = 1'b1, wr_valid = 1'b0;
  logic [7:0]    wr_data = 8'h00;

  pport_block_xfer #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir), .count(count),
    .busy(busy), .done(done), .bus_dout(bus_dout), .bus_din(bus_din),
    .ctl_out(ctl_out), .ctl_in(ctl_in), .stat_in(stat_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready)
  );

  int total = 0, bad = 0, cyc = 0, dn = 0, wd = 0;
  logic [8:0] ev_q[$];
  logic [7:0] rd_q[$];
  logic [7:0] wq[$];
  logic [7:0] src [0:63];
  logic [7:0] dat [0:63];
  logic [6:0] rd_idx = 7'd0;
  logic [1:0] pm = 2'd0;
  logic [7:0] sh_d = 8'h00, sh_c = 8'h04, pv_d = 8'h00, pv_c = 8'h04;
  logic       wr_take = 1'b0, st_rd = 1'b0, st_wr = 1'b0, gap = 1'b0;
  logic [15:0] lf = 16'hACE1;
  string      tag = "R1";

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // bridge model: answers only on the strobe value the expected phase calls for
  always_comb begin
    logic       ph;
    logic [7:0] cur;
    ph      = ~rd_idx[0];
    cur     = src[rd_idx[5:0]];
    stat_in = 8'h3C;
    ctl_in  = 8'h00;
    bus_din = 8'h5A;
    if (pm == 2'd0) begin
      if (ctl_out == (8'h02 | {7'd0, ph}))      stat_in = {cur[3:0], 4'h5};
      else if (ctl_out == (8'h04 | {7'd0, ph})) stat_in = {cur[7:4], 4'hA};
    end else if (pm == 2'd1) begin
      if (ctl_out == (8'h04 | {7'd0, ph})) begin
        stat_in = {cur[4:0], 3'b101};
        ctl_in  = {4'hA, cur[7:5], 1'b1};
      end
    end else if (ctl_out == (8'h24 | {7'd0, ph})) begin
      bus_din = cur;
    end
  end

  task automatic pop_ev(input logic [8:0] got);
    logic [8:0] e;
    if (ev_q.size() == 0) begin
      chk(1'b0, tag, int'(got), 0);
    end else begin
      e = ev_q.pop_front();
      chk(e == got, tag, int'(got), int'(e));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_dout != pv_d) begin pop_ev({1'b0, bus_dout}); pv_d = bus_dout; end
      if (ctl_out != pv_c)  begin pop_ev({1'b1, ctl_out});  pv_c = ctl_out;  end
      if (busy) cyc++;
      if (done) dn++;
      if (rd_valid && rd_ready) begin
        if (rd_q.size() == 0) chk(1'b0, tag, int'(rd_data), 0);
        else begin
          logic [7:0] x;
          x = rd_q.pop_front();
          chk(rd_data == x, tag, int'(rd_data), int'(x));
        end
        rd_idx = rd_idx + 7'd1;
      end
      wr_take = wr_valid && wr_ready;
    end
  end

  // stream driver
  always @(posedge clk) begin
    #1;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    rd_ready = !st_rd || lf[0];
    if (wr_take) begin
      void'(wq.pop_front());
      wr_take = 1'b0;
    end
    gap      = st_wr && lf[1];
    wr_valid = (wq.size() > 0) && !gap;
    wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pe(input bit c, input logic [7:0] v);
    if (c) begin
      if (v != sh_c) begin ev_q.push_back({1'b1, v}); sh_c = v; end
    end else begin
      if (v != sh_d) begin ev_q.push_back({1'b0, v}); sh_d = v; end
    end
  endtask

  task automatic run(input logic [1:0] m, input bit w, input int n, input int expc,
                     input bit srd, input bit swr, input bit poke, input string t);
    logic ph;
    tag = t;
    ph  = !w;
    if (w) begin
      pe(0, 8'hA1); pe(1, 8'h01); pe(1, 8'h03); pe(1, 8'h01); pe(1, 8'h05);
    end else if (m == 2'd0) begin
      pe(0, 8'h81); pe(1, 8'h01); pe(1, 8'h03); pe(0, 8'hC1);
    end else if (m == 2'd1) begin
      pe(0, 8'h91); pe(1, 8'h01); pe(0, 8'h10); pe(1, 8'h03);
      pe(0, 8'h51); pe(1, 8'h05); pe(0, 8'hD1);
    end else begin
      pe(0, 8'h89); pe(1, 8'h01); pe(1, 8'h23); pe(1, 8'h21);
    end
    for (int k = 0; k < n; k++) begin
      if (w) begin
        wq.push_back(dat[k]);
        if (k == 0 || dat[k] != dat[k-1]) pe(0, dat[k]);
        pe(1, 8'h04 | {7'd0, ph});
      end else begin
        src[k] = dat[k];
        rd_q.push_back(dat[k]);
        if (m == 2'd0) begin pe(1, 8'h02 | {7'd0, ph}); pe(1, 8'h04 | {7'd0, ph}); end
        else if (m == 2'd1) pe(1, 8'h04 | {7'd0, ph});
        else pe(1, 8'h24 | {7'd0, ph});
      end
      ph = ~ph;
    end
    if (w)         begin pe(1, 8'h07); pe(1, 8'h04); end
    else if (m[1]) begin pe(1, 8'h06); pe(1, 8'h04); end
    else           begin pe(0, 8'h00); pe(1, 8'h04); end
    pm = m; rd_idx = 7'd0; cyc = 0; dn = 0; st_rd = srd; st_wr = swr;
    @(posedge clk); #1;
    mode = m; dir = w; count = CW'(n); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (6) @(posedge clk);
      #1; start = 1'b1; mode = ~m; dir = ~w; count = CW'(3);
      @(posedge clk); #1; start = 1'b0;
    end
    while (dn == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    if (expc >= 0) chk(cyc == expc, "R12 cycles", cyc, expc);
    chk(dn == 1, "R11 done pulses", dn, 1);
    chk(ev_q.size() == 0, {t, " pending line events"}, ev_q.size(), 0);
    chk(rd_q.size() == 0, {t, " pending read bytes"}, rd_q.size(), 0);
    chk(wq.size() == 0, {t, " pending write bytes"}, wq.size(), 0);
    chk(!busy && ctl_out == 8'h04, "R1 idle control", int'(ctl_out), 8'h04);
    st_rd = 1'b0; st_wr = 1'b0;
    ev_q.delete(); rd_q.delete(); wq.delete();
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin src[k] = 8'h00; dat[k] = 8'h00; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_out == 8'h04 && bus_dout == 8'h00 && !busy && !done && !rd_valid && !wr_ready,
        "R1 reset state", int'({ctl_out, bus_dout}), 16'h0400);

    for (int k = 0; k < 64; k++) dat[k] = 8'(k * 37 + 11);
    run(2'd0, 1'b0, 5, 4 + 5*4 + 3, 1'b0, 1'b0, 1'b0, "R2");
    for (int k = 0; k < 64; k++) dat[k] = 8'(k * 91 + 200);
    run(2'd1, 1'b0, 6, 7 + 6*3 + 3, 1'b0, 1'b0, 1'b0, "R3");
    run(2'd2, 1'b0, 4, 4 + 4*3 + 3, 1'b0, 1'b0, 1'b0, "R4");
    run(2'd3, 1'b0, 3, 4 + 3*3 + 3, 1'b0, 1'b0, 1'b0, "R4");
    run(2'd1, 1'b0, 0, 7 + 3, 1'b0, 1'b0, 1'b0, "R5");
    run(2'd0, 1'b0, 0, 4 + 3, 1'b0, 1'b0, 1'b0, "R10");
    run(2'd2, 1'b1, 0, 5 + 3, 1'b0, 1'b0, 1'b0, "R10");

    for (int k = 0; k < 64; k++) dat[k] = 8'(k * 23 + 5);
    run(2'd1, 1'b1, 5, 5 + 5*2 + 3, 1'b0, 1'b0, 1'b0, "R6");
    dat[0] = 8'hA1; dat[1] = 8'hA1; dat[2] = 8'h33; dat[3] = 8'h33; dat[4] = 8'h33; dat[5] = 8'h7E;
    run(2'd0, 1'b1, 6, 5 + 9 + 3, 1'b0, 1'b0, 1'b0, "R7");

    for (int k = 0; k < 64; k++) dat[k] = 8'(k * 59 + 3);
    run(2'd0, 1'b0, 12, -1, 1'b1, 1'b0, 1'b0, "R8");
    run(2'd1, 1'b0, 9, -1, 1'b1, 1'b0, 1'b0, "R8");
    for (int k = 0; k < 64; k++) dat[k] = 8'((k / 3) * 77 + 1);
    run(2'd2, 1'b1, 14, -1, 1'b0, 1'b1, 1'b0, "R9");

    for (int k = 0; k < 64; k++) dat[k] = 8'(k * 13 + 101);
    run(2'd2, 1'b0, 10, 4 + 10*3 + 3, 1'b0, 1'b0, 1'b1, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule